// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous 1024 x 8 memory with two fully independent ports, called left and right. Each port has its own active-low select, active-low output enable, a read/write strobe (low means write), a 10-bit address, write data and registered read data. Both ports may read or write any word in the same clock cycle.

When the mailbox mode input is high, the two highest words take on a signalling role. A right-port write to 0x3FE pulls the left interrupt low. A left-port write to 0x3FF pulls the right interrupt low. Each receiving port clears its own interrupt by selecting its mailbox word with the output enable active. The mailbox words still hold ordinary data. When the mode input is low, both words are plain memory and both interrupts stay inactive.

When both ports are selected at the same address in the same cycle, the left port always wins. The right port sees its busy output go low in that same cycle, and any write it attempts in that cycle is discarded.

Top module: `dpram_mbox`

## Requirements
- R1: A write (select low, read/write low) stores the data at the clock edge. A read (select low, read/write high, output enable low) places the stored word on that port's read data one cycle later. The read returns the value held before that edge, and either port can read a word the other port wrote.
- R2: A port whose select is high writes nothing. A port that is not reading (select high, output enable high, or read/write low) shows 0x00 on its read data after the next edge.
- R3: With mailbox mode on, a right-port write to address 0x3FE that is not blocked drives the left interrupt low (active) after that edge. The right interrupt is left unchanged.
- R4: The left interrupt returns high after an edge at which the left port has select low, output enable low and address 0x3FE, whatever its read/write level. An access at 0x3FE with output enable high does not clear it.
- R5: With mailbox mode on, a left-port write to 0x3FF drives the right interrupt low after that edge. A right-port access at 0x3FF with select and output enable low clears it.
- R6: Words 0x3FE and 0x3FF store and return data like any other address.
- R7: With mailbox mode off, writes to 0x3FE and 0x3FF raise no interrupt and store their data normally. Both interrupts are high after any edge with mailbox mode off.
- R8: While both selects are low and the addresses are equal, the right busy output is low in that same cycle. The left busy output is always high. Busy is high whenever either port is deselected or the addresses differ.
- R9: A right-port write made while right busy is low leaves the word unchanged. A left write in that same cycle takes effect.
- R10: After reset, both interrupts are high and both read data outputs are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| mbox_en | input | 1 | 1 turns on the mailbox function of 0x3FE/0x3FF |
| l_cs_n | input | 1 | left select, active low |
| l_oe_n | input | 1 | left output enable, active low |
| l_we_n | input | 1 | left read/write, low = write |
| l_addr | input | 10 | left address |
| l_wdata | input | 8 | left write data |
| l_rdata | output | 8 | left read data, registered |
| l_busy_n | output | 1 | left busy, active low (left has priority) |
| l_irq_n | output | 1 | left interrupt, active low |
| r_cs_n | input | 1 | right select, active low |
| r_oe_n | input | 1 | right output enable, active low |
| r_we_n | input | 1 | right read/write, low = write |
| r_addr | input | 10 | right address |
| r_wdata | input | 8 | right write data |
| r_rdata | output | 8 | right read data, registered |
| r_busy_n | output | 1 | right busy, active low |
| r_irq_n | output | 1 | right interrupt, active low |

## Verification
Busy is combinational, so the bench checks it 1 ns after it drives the inputs on a falling edge, within the same cycle. Read data and both interrupts are registered, so each is due one rising edge after the access that causes it. The driver queues the expected value of each such output just before the rising edge that produces it. The monitor compares the queue 2 ns after that edge, which is the first point where the new value can be seen and before the next stimulus changes anything.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
  parameter int ADDR_W = 10;
  parameter int DATA_W = 8;
  localparam int DEPTH = 1 << ADDR_W;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  // mailbox owned by the left receiver, and by the right receiver
  localparam addr_t MB_LEFT  = addr_t'(DEPTH - 2);
  localparam addr_t MB_RIGHT = addr_t'(DEPTH - 1);
endpackage

// File: rtl/dpram_arb.sv
`timescale 1ns/1ps
module dpram_arb
  import dpram_pkg::*;
(
  input  logic  l_sel,
  input  logic  r_sel,
  input  addr_t l_addr,
  input  addr_t r_addr,
  input  logic  l_wr_req,
  input  logic  r_wr_req,
  output logic  r_lose,
  output logic  l_wr_ok,
  output logic  r_wr_ok
);
  // fixed priority: left always proceeds, right yields on same address
  always_comb begin
    r_lose  = l_sel && r_sel && (l_addr == r_addr);
    l_wr_ok = l_wr_req;
    r_wr_ok = r_wr_req && !r_lose;
  end
endmodule

// File: rtl/dpram_core.sv
`timescale 1ns/1ps
module dpram_core
  import dpram_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t l_addr,
  input  data_t l_wdata,
  input  logic  l_wr_en,
  input  logic  l_rd,
  input  addr_t r_addr,
  input  data_t r_wdata,
  input  logic  r_wr_req,
  input  logic  r_wr_en,
  input  logic  r_rd,
  output data_t l_rdata,
  output data_t r_rdata
);
  data_t mem [DEPTH];
  data_t l_rdata_nx, r_rdata_nx;

  // storage: no reset on the array
  always_ff @(posedge clk) begin
    if (l_wr_en) mem[l_addr] <= l_wdata;
    if (r_wr_en) mem[r_addr] <= r_wdata;
  end

  always_comb begin
    l_rdata_nx = l_rd ? mem[l_addr] : '0;
    r_rdata_nx = r_rd ? mem[r_addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      l_rdata <= l_rdata_nx;
      r_rdata <= r_rdata_nx;
    end
  end

  // R2: a port that did not read shows zero
  a_r2_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> (l_rdata == '0));
  // R9: a blocked right write leaves the word untouched
  a_r9_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr_req && !r_wr_en && !l_wr_en) |=> (mem[$past(r_addr)] == $past(mem[r_addr])));
endmodule

// File: rtl/dpram_mailbox.sv
`timescale 1ns/1ps
module dpram_mailbox (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_l,
  input  logic clr_l,
  input  logic set_r,
  input  logic clr_r,
  output logic l_irq_n,
  output logic r_irq_n
);
  logic l_irq_nx, r_irq_nx;

  // set wins over clear; disabled mode forces both inactive
  always_comb begin
    l_irq_nx = l_irq_n;
    r_irq_nx = r_irq_n;
    if (!enable) begin
      l_irq_nx = 1'b1;
      r_irq_nx = 1'b1;
    end else begin
      if (set_l)      l_irq_nx = 1'b0;
      else if (clr_l) l_irq_nx = 1'b1;
      if (set_r)      r_irq_nx = 1'b0;
      else if (clr_r) r_irq_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_irq_n <= 1'b1;
      r_irq_n <= 1'b1;
    end else begin
      l_irq_n <= l_irq_nx;
      r_irq_n <= r_irq_nx;
    end
  end

  // R3: the left flag only falls after a right mailbox write
  a_r3_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_irq_n) |-> $past(set_l && enable));
  // R4: clear takes effect when no set competes
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clr_l && !set_l) |=> l_irq_n);
  // R7: disabled mode keeps both flags inactive
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (l_irq_n && r_irq_n));
endmodule

// File: rtl/dpram_mbox.sv
`timescale 1ns/1ps
module dpram_mbox
  import dpram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_en,
  input  logic              l_cs_n,
  input  logic              l_oe_n,
  input  logic              l_we_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_busy_n,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_oe_n,
  input  logic              r_we_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_busy_n,
  output logic              r_irq_n
);
  logic rst_q1, rst_q2;
  logic l_sel, r_sel, l_wr_req, r_wr_req, l_rd, r_rd;
  logic r_lose, l_wr_ok, r_wr_ok;
  logic set_l, clr_l, set_r, clr_r;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  always_comb begin
    l_sel    = !l_cs_n;
    r_sel    = !r_cs_n;
    l_wr_req = l_sel && !l_we_n;
    r_wr_req = r_sel && !r_we_n;
    l_rd     = l_sel && l_we_n && !l_oe_n;
    r_rd     = r_sel && r_we_n && !r_oe_n;
    set_l    = r_wr_ok && (r_addr == MB_LEFT);
    set_r    = l_wr_ok && (l_addr == MB_RIGHT);
    clr_l    = l_sel && !l_oe_n && (l_addr == MB_LEFT);
    clr_r    = r_sel && !r_oe_n && (r_addr == MB_RIGHT);
    l_busy_n = 1'b1;
    r_busy_n = !r_lose;
  end

  dpram_arb u_arb (
    .l_sel(l_sel), .r_sel(r_sel), .l_addr(l_addr), .r_addr(r_addr),
    .l_wr_req(l_wr_req), .r_wr_req(r_wr_req),
    .r_lose(r_lose), .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  dpram_core u_core (
    .clk(clk), .rst_n(rst_q2),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_wr_en(l_wr_ok), .l_rd(l_rd),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_wr_req(r_wr_req),
    .r_wr_en(r_wr_ok), .r_rd(r_rd),
    .l_rdata(l_rdata), .r_rdata(r_rdata)
  );

  dpram_mailbox u_mbox (
    .clk(clk), .rst_n(rst_q2), .enable(mbox_en),
    .set_l(set_l), .clr_l(clr_l), .set_r(set_r), .clr_r(clr_r),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  // R8: right busy only when both ports are selected
  a_r8_busy_needs_both: assert property (@(posedge clk) disable iff (!rst_q2)
    !r_busy_n |-> (!l_cs_n && !r_cs_n && (l_addr == r_addr)));
  // R5: right flag falls only after a left write to its mailbox
  a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_q2)
    $fell(r_irq_n) |-> $past(!l_cs_n && !l_we_n && (l_addr == MB_RIGHT) && mbox_en));
endmodule

// File: tb/dpram_mbox_test.sv
`timescale 1ns/1ps
module dpram_mbox_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mbox_en = 1'b1;
  logic l_cs_n = 1, l_oe_n = 1, l_we_n = 1, r_cs_n = 1, r_oe_n = 1, r_we_n = 1;
  logic [9:0] l_addr = '0, r_addr = '0;
  logic [7:0] l_wdata = '0, r_wdata = '0;
  logic [7:0] l_rdata, r_rdata;
  logic l_busy_n, r_busy_n, l_irq_n, r_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int sel; logic [7:0] exp; string req; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  dpram_mbox uut (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy_n(l_busy_n), .l_irq_n(l_irq_n),
    .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy_n(r_busy_n), .r_irq_n(r_irq_n)
  );

  function automatic logic [7:0] pick(int sel);
    case (sel)
      0: return l_rdata;
      1: return r_rdata;
      2: return {7'd0, l_irq_n};
      default: return {7'd0, r_irq_n};
    endcase
  endfunction

  task automatic cmp(int sel, logic [7:0] exp, string req);
    logic [7:0] act;
    act = pick(sel);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s output %0d actual=%h expected=%h", req, sel, act, exp);
    end
  endtask

  // monitor: results are due 2 ns after the edge that makes them
  always @(posedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.sel, it.exp, it.req);
    end
  end

  task automatic expect_o(int sel, logic [7:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic lport(bit cs, bit oe, bit we, logic [9:0] a, logic [7:0] d);
    l_cs_n = cs; l_oe_n = oe; l_we_n = we; l_addr = a; l_wdata = d;
  endtask
  task automatic rport(bit cs, bit oe, bit we, logic [9:0] a, logic [7:0] d);
    r_cs_n = cs; r_oe_n = oe; r_we_n = we; r_addr = a; r_wdata = d;
  endtask
  task automatic idle();
    lport(1, 1, 1, 0, 0);
    rport(1, 1, 1, 0, 0);
  endtask
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask
  task automatic chk_busy(bit el, bit er, string req);
    #1;
    checks++;
    if (l_busy_n !== el || r_busy_n !== er) begin
      errors++;
      $display("FAIL %s busy actual=%b%b expected=%b%b", req, l_busy_n, r_busy_n, el, er);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    cmp(0, 8'h00, "R10"); cmp(1, 8'h00, "R10");
    cmp(2, 8'h01, "R10"); cmp(3, 8'h01, "R10");

    // R1: write left, read right; concurrent writes at distinct addresses
    lport(0, 1, 0, 10'h005, 8'hA5); tick();
    lport(1, 1, 1, 0, 0); rport(0, 0, 1, 10'h005, 0);
    expect_o(1, 8'hA5, "R1"); tick();
    lport(0, 1, 0, 10'h123, 8'h3C); rport(0, 1, 0, 10'h200, 8'hC3);
    chk_busy(1, 1, "R8"); tick();
    lport(0, 0, 1, 10'h200, 0); rport(0, 0, 1, 10'h123, 0);
    expect_o(0, 8'hC3, "R1"); expect_o(1, 8'h3C, "R1"); tick();

    // R2: deselected write, outputs idle
    idle(); lport(1, 0, 0, 10'h005, 8'hFF); tick();
    lport(0, 1, 1, 10'h005, 0); expect_o(0, 8'h00, "R2"); tick();
    lport(1, 0, 1, 10'h005, 0); expect_o(0, 8'h00, "R2"); tick();
    lport(0, 0, 1, 10'h005, 0); expect_o(0, 8'hA5, "R2"); tick();

    // R3, R4, R6: right to left mailbox
    idle(); rport(0, 1, 0, 10'h3FE, 8'h5A);
    expect_o(2, 8'h00, "R3"); expect_o(3, 8'h01, "R3"); tick();
    idle(); expect_o(2, 8'h00, "R3"); tick();
    lport(0, 1, 1, 10'h3FE, 0); expect_o(2, 8'h00, "R4"); tick();
    lport(0, 0, 1, 10'h3FE, 0);
    expect_o(0, 8'h5A, "R6"); expect_o(2, 8'h01, "R4"); tick();
    idle(); rport(0, 1, 0, 10'h3FE, 8'h11); expect_o(2, 8'h00, "R3"); tick();
    idle(); lport(0, 0, 0, 10'h3FE, 8'h22); expect_o(2, 8'h01, "R4"); tick();
    lport(0, 0, 1, 10'h3FE, 0); expect_o(0, 8'h22, "R6"); tick();

    // R5: left to right mailbox
    idle(); lport(0, 1, 0, 10'h3FF, 8'h77);
    expect_o(3, 8'h00, "R5"); expect_o(2, 8'h01, "R5"); tick();
    idle(); rport(0, 0, 1, 10'h3FF, 0);
    expect_o(1, 8'h77, "R5"); expect_o(3, 8'h01, "R5"); tick();

    // R7: mailbox off
    idle(); mbox_en = 1'b0; rport(0, 1, 0, 10'h3FE, 8'h99);
    expect_o(2, 8'h01, "R7"); tick();
    idle(); lport(0, 1, 0, 10'h3FF, 8'h88); expect_o(3, 8'h01, "R7"); tick();
    idle(); lport(0, 0, 1, 10'h3FE, 0); rport(0, 0, 1, 10'h3FF, 0);
    expect_o(0, 8'h99, "R7"); expect_o(1, 8'h88, "R7"); tick();
    idle(); mbox_en = 1'b1; rport(0, 1, 0, 10'h3FE, 8'h44);
    expect_o(2, 8'h00, "R7"); tick();
    idle(); mbox_en = 1'b0; expect_o(2, 8'h01, "R7"); tick();
    mbox_en = 1'b1;

    // R8, R9: collisions
    idle(); lport(0, 1, 0, 10'h040, 8'h12); rport(0, 1, 0, 10'h040, 8'h34);
    chk_busy(1, 0, "R8"); tick();
    idle(); lport(0, 0, 1, 10'h040, 0); expect_o(0, 8'h12, "R9"); tick();
    idle(); lport(0, 1, 0, 10'h050, 8'hAA); tick();
    lport(0, 0, 1, 10'h050, 0); rport(0, 1, 0, 10'h050, 8'hBB);
    chk_busy(1, 0, "R8"); expect_o(0, 8'hAA, "R9"); tick();
    idle(); rport(0, 0, 1, 10'h050, 0); expect_o(1, 8'hAA, "R9"); tick();
    idle(); lport(1, 1, 0, 10'h060, 0); rport(0, 1, 0, 10'h060, 8'h5C);
    chk_busy(1, 1, "R8"); tick();
    // R3 under collision: blocked right mailbox write raises nothing
    idle(); lport(0, 1, 1, 10'h3FE, 0); rport(0, 1, 0, 10'h3FE, 8'h66);
    chk_busy(1, 0, "R8"); expect_o(2, 8'h01, "R3"); tick();
    idle(); rport(0, 0, 1, 10'h060, 0); expect_o(1, 8'h5C, "R1"); tick();

    idle(); tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule